// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental quadrature encoder into a position count and a direction flag. Each raw phase is brought into the clock domain through a two-flop synchronizer. It can then be inverted and passed through a programmable glitch filter. After that, the block compares the conditioned levels with their values one cycle earlier to find transitions.

A single-channel transition produces a direction decision. When the selected counting mode accepts that channel, it also produces a count step. The counter moves between zero and a programmable reload value and wraps at either end. Each wrap raises a one-cycle pulse.

Software or a neighbouring block drives the mode, enable, polarity, filter length and reload inputs directly. Direction keeps tracking the encoder even when counting is stopped or restricted to one channel.

Top module: `qenc_counter_top`

## Requirements
- R1: While `rst` is high and on the cycle after it, `count` is 0, `dir_down` is 0 (0 means counting up) and `wrap` is 0.
- R2: Mode encoding: `mode`=2'b01 counts transitions of channel B only, 2'b10 counts channel A only, 2'b11 counts both, and 2'b00 counts none.
- R3: On a channel A transition the direction is down when the conditioned A equals the conditioned B after the transition. On a channel B transition it is down when B differs from A after the transition. Each count step moves one in that direction.
- R4: `dir_down` is updated on every single-channel transition whatever `mode` and `en` are.
- R5: `count` changes only when `en` is 1.
- R6: A step up from a count equal to or above `reload` gives 0 and raises `wrap`.
- R7: A step down from 0 gives `reload` and raises `wrap`.
- R8: `wrap` is high for exactly one cycle per wrap and is otherwise low.
- R9: When both conditioned channels change in the same cycle, neither `count` nor `dir_down` changes.
- R10: Inversion is applied before transition detection: toggling `inv_a` with a steady input acts as a channel A transition.
- R11: With filter length N, a new level on a channel is accepted only after N+1 consecutive synchronized samples of that level. Shorter pulses have no effect.
- R12: With filter length 0, a raw change driven between clock edges reaches `count` on the fourth rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_a_raw | input | 1 | Encoder phase A, asynchronous |
| ch_b_raw | input | 1 | Encoder phase B, asynchronous |
| inv_a | input | 1 | Invert channel A |
| inv_b | input | 1 | Invert channel B |
| flt_a | input | FLT_W | Filter length for channel A |
| flt_b | input | FLT_W | Filter length for channel B |
| mode | input | 2 | Counting mode (see R2) |
| en | input | 1 | Counter enable |
| reload | input | CNT_W | Upper count limit |
| count | output | CNT_W | Position count |
| dir_down | output | 1 | 1 when the last decision was down |
| wrap | output | 1 | One-cycle pulse on wrap in either direction |

## Verification
The range and wrap properties assume that `reload` is held steady and that the count starts inside the range 0 to `reload`. The stimulus therefore fixes `reload` for the whole run and starts counting from reset. The bench moves the encoder through the Gray sequence and holds each level for several cycles, so the filter and synchronizer latency always settle before the next change. Simultaneous changes and short glitches are applied only in dedicated directed steps.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    typedef enum logic [1:0] {
        QM_OFF    = 2'b00,
        QM_B_ONLY = 2'b01,
        QM_A_ONLY = 2'b10,
        QM_BOTH   = 2'b11
    } qmode_e;

    // conditioned levels plus transition flags of one cycle
    typedef struct packed {
        logic edge_a;
        logic edge_b;
        logic lvl_a;
        logic lvl_b;
    } qsamp_t;

    // decoded step request
    typedef struct packed {
        logic valid;
        logic down;
        logic cnt_req;
    } qstep_t;

    function automatic logic step_is_down(qsamp_t s);
        if (s.edge_a)
            return (s.lvl_a == s.lvl_b);
        return (s.lvl_a != s.lvl_b);
    endfunction

    function automatic logic mode_counts(qmode_e m, qsamp_t s);
        case (m)
            QM_B_ONLY: return s.edge_b;
            QM_A_ONLY: return s.edge_a;
            QM_BOTH:   return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/qenc_chan_cond.sv
module qenc_chan_cond #(
    parameter int FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw,
    input  logic             inv,
    input  logic [FLT_W-1:0] flt_len,
    output logic             lvl
);
    logic [1:0]       sync_q;
    logic             pol;
    logic [FLT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[0], raw};
    end

    assign pol = sync_q[1] ^ inv;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl   <= 1'b0;
            run_q <= '0;
        end else if (pol == lvl) begin
            run_q <= '0;
        end else if (run_q >= flt_len) begin
            lvl   <= pol;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/qenc_step_gen.sv
module qenc_step_gen
    import qenc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   lvl_a,
    input  logic   lvl_b,
    input  qmode_e mode,
    output qstep_t step
);
    logic   prev_a, prev_b;
    qsamp_t samp;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
        end else begin
            prev_a <= lvl_a;
            prev_b <= lvl_b;
        end
    end

    always_comb begin
        samp.edge_a  = lvl_a ^ prev_a;
        samp.edge_b  = lvl_b ^ prev_b;
        samp.lvl_a   = lvl_a;
        samp.lvl_b   = lvl_b;
        step.valid   = samp.edge_a ^ samp.edge_b;
        step.down    = step_is_down(samp);
        step.cnt_req = step.valid && mode_counts(mode, samp);
    end
endmodule

// File: rtl/qenc_wrap_cnt.sv
module qenc_wrap_cnt
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  qstep_t           step,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             wrap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            dir_down <= 1'b0;
            wrap     <= 1'b0;
        end else begin
            wrap <= 1'b0;
            if (step.valid)
                dir_down <= step.down;
            if (en && step.cnt_req) begin
                if (step.down) begin
                    if (count == '0) begin
                        count <= reload;
                        wrap  <= 1'b1;
                    end else begin
                        count <= count - 1'b1;
                    end
                end else begin
                    if (count >= reload) begin
                        count <= '0;
                        wrap  <= 1'b1;
                    end else begin
                        count <= count + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/qenc_counter_top.sv
module qenc_counter_top
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ch_a_raw,
    input  logic             ch_b_raw,
    input  logic             inv_a,
    input  logic             inv_b,
    input  logic [FLT_W-1:0] flt_a,
    input  logic [FLT_W-1:0] flt_b,
    input  logic [1:0]       mode,
    input  logic             en,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             wrap
);
    localparam int NCH = 2;

    logic [NCH-1:0]       raw_v, inv_v, lvl_v;
    logic [FLT_W-1:0]     flt_v [NCH];
    qstep_t               step;

    assign raw_v    = {ch_b_raw, ch_a_raw};
    assign inv_v    = {inv_b, inv_a};
    assign flt_v[0] = flt_a;
    assign flt_v[1] = flt_b;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        qenc_chan_cond #(.FLT_W(FLT_W)) u_cond (
            .clk     (clk),
            .rst     (rst),
            .raw     (raw_v[i]),
            .inv     (inv_v[i]),
            .flt_len (flt_v[i]),
            .lvl     (lvl_v[i])
        );
    end

    qenc_step_gen u_step (
        .clk   (clk),
        .rst   (rst),
        .lvl_a (lvl_v[0]),
        .lvl_b (lvl_v[1]),
        .mode  (qmode_e'(mode)),
        .step  (step)
    );

    qenc_wrap_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .step     (step),
        .reload   (reload),
        .count    (count),
        .dir_down (dir_down),
        .wrap     (wrap)
    );
endmodule

// File: rtl/qenc_chk.sv
module qenc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode,
    input logic             en,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] count,
    input logic             dir_down,
    input logic             wrap
);
    // R5
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count));

    // R2
    mode_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |=> $stable(count));

    // R6
    up_wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap && !dir_down) |-> (count == '0));

    // R7
    down_wrap_top_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap && dir_down && $stable(reload)) |-> (count == reload));

    // R3
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!wrap && !$stable(count)) |->
            ((count == CNT_W'($past(count) + 1'b1)) ||
             (count == CNT_W'($past(count) - 1'b1))));

    // R6
    in_range_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(reload) && ($past(count) <= $past(reload))) |-> (count <= reload));
endmodule

bind qenc_counter_top qenc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .en       (en),
    .reload   (reload),
    .count    (count),
    .dir_down (dir_down),
    .wrap     (wrap)
);

// File: tb/sim_qenc_counter_top.sv
module sim_qenc_counter_top;
    localparam int CNT_W = 16;
    localparam int FLT_W = 4;
    localparam int NV    = 17;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ch_a_raw = 1'b0, ch_b_raw = 1'b0, inv_a = 1'b0, inv_b = 1'b0, en = 1'b1;
    logic [FLT_W-1:0] flt_a = '0, flt_b = '0;
    logic [1:0]       mode = 2'b11;
    logic [CNT_W-1:0] reload = 16'd5;
    logic [CNT_W-1:0] count;
    logic             dir_down, wrap;

    int checks = 0, errors = 0, wraps = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    qenc_counter_top #(.CNT_W(CNT_W), .FLT_W(FLT_W)) u0 (
        .clk(clk), .rst(rst), .ch_a_raw(ch_a_raw), .ch_b_raw(ch_b_raw),
        .inv_a(inv_a), .inv_b(inv_b), .flt_a(flt_a), .flt_b(flt_b),
        .mode(mode), .en(en), .reload(reload),
        .count(count), .dir_down(dir_down), .wrap(wrap)
    );

    always @(negedge clk) if (!rst && wrap) wraps++;

    // fields: mode[11:10] a[9] b[8] count[7:4] dir[3] pad[2] wraps[1:0]
    localparam logic [11:0] VEC [NV] = '{
        {2'b11, 1'b1, 1'b0, 4'd1, 1'b0, 1'b0, 2'd0},
        {2'b11, 1'b1, 1'b1, 4'd2, 1'b0, 1'b0, 2'd0},
        {2'b11, 1'b0, 1'b1, 4'd3, 1'b0, 1'b0, 2'd0},
        {2'b11, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0, 2'd0},
        {2'b11, 1'b1, 1'b0, 4'd5, 1'b0, 1'b0, 2'd0},
        {2'b11, 1'b1, 1'b1, 4'd0, 1'b0, 1'b0, 2'd1},
        {2'b11, 1'b1, 1'b0, 4'd5, 1'b1, 1'b0, 2'd2},
        {2'b11, 1'b0, 1'b0, 4'd4, 1'b1, 1'b0, 2'd2},
        {2'b11, 1'b0, 1'b1, 4'd3, 1'b1, 1'b0, 2'd2},
        {2'b01, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0, 2'd2},
        {2'b01, 1'b1, 1'b0, 4'd4, 1'b0, 1'b0, 2'd2},
        {2'b01, 1'b0, 1'b0, 4'd4, 1'b1, 1'b0, 2'd2},
        {2'b01, 1'b0, 1'b1, 4'd3, 1'b1, 1'b0, 2'd2},
        {2'b10, 1'b1, 1'b1, 4'd2, 1'b1, 1'b0, 2'd2},
        {2'b10, 1'b1, 1'b0, 4'd2, 1'b1, 1'b0, 2'd2},
        {2'b10, 1'b1, 1'b1, 4'd2, 1'b0, 1'b0, 2'd2},
        {2'b10, 1'b0, 1'b1, 4'd3, 1'b0, 1'b0, 2'd2}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic put(input logic a, input logic b);
        @(negedge clk);
        ch_a_raw = a;
        ch_b_raw = b;
        settle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 count in reset", int'(count), 0);
        check("R1 dir in reset", int'(dir_down), 0);
        check("R1 wrap in reset", int'(wrap), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 count after reset", int'(count), 0);

        // table walk: R2 R3 R4 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            mode = VEC[i][11:10];
            put(VEC[i][9], VEC[i][8]);
            check($sformatf("R3 R6 R7 count row %0d", i), int'(count), int'(VEC[i][7:4]));
            check($sformatf("R4 dir row %0d", i), int'(dir_down), int'(VEC[i][3]));
            check($sformatf("R8 wrap tally row %0d", i), wraps, int'(VEC[i][1:0]));
        end

        // R2 mode off: B edge, direction up, no count
        mode = 2'b00;
        put(1'b0, 1'b0);
        check("R2 mode off count", int'(count), 3);
        check("R4 mode off dir", int'(dir_down), 0);

        // R5 enable low, direction still tracked
        mode = 2'b11;
        en = 1'b0;
        put(1'b1, 1'b0);
        check("R5 disabled count", int'(count), 3);
        put(1'b0, 1'b0);
        check("R5 disabled count rev", int'(count), 3);
        check("R4 disabled dir", int'(dir_down), 1);
        en = 1'b1;

        // R9 both channels change together
        put(1'b1, 1'b1);
        check("R9 dual change count", int'(count), 3);
        check("R9 dual change dir", int'(dir_down), 1);

        // R10 inversion toggle acts as an A edge
        @(negedge clk); inv_a = 1'b1; settle();
        check("R10 invert count", int'(count), 4);
        check("R10 invert dir", int'(dir_down), 0);
        @(negedge clk); inv_a = 1'b0; settle();
        check("R10 uninvert count", int'(count), 3);

        // R12 latency: state a=1 b=1 count 3, A falls -> up
        @(negedge clk); ch_a_raw = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 before fourth edge", int'(count), 3);
        @(negedge clk);
        check("R12 at fourth edge", int'(count), 4);
        settle();

        // R11 filter length 3 on A; state a=0 b=1 count 4
        flt_a = 4'd3;
        @(negedge clk); ch_a_raw = 1'b1;
        repeat (3) @(negedge clk); ch_a_raw = 1'b0;
        settle();
        check("R11 glitch ignored", int'(count), 4);
        @(negedge clk); ch_a_raw = 1'b1;
        repeat (12) @(negedge clk);
        check("R11 held level accepted", int'(count), 3);
        check("R11 held level dir", int'(dir_down), 1);
        flt_a = '0;

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check("R1 count after mid reset", int'(count), 0);
        check("R1 dir after mid reset", int'(dir_down), 0);
        rst = 1'b0;

        finish_run();
    end
endmodule